// File: doc/BRIEF.md
# Serial Bus FIFO Pair and Interrupt Unit

This block sits between the register interface of a serial bus controller and its bus engine. It holds a byte FIFO in each direction. Software pushes transmit bytes and pops receive bytes through a small register set. The bus engine drains the transmit FIFO and fills the receive FIFO through a valid/take and ready/put handshake.

Each FIFO reports empty, full and a threshold event, and the threshold is programmable from 0 to 15. Each FIFO also has a flush command that clears itself after a fixed number of cycles. Some conditions are latched: a write to a full transmit FIFO, and four completion or error pulses from the bus engine. All of these appear in a raw status word. A mask register selects which of them drive a single interrupt line. A write-one-to-clear register clears the latched bits.

Registers are selected by a 3-bit `regSel`:

| regSel | Register | Access |
|---|---|---|
| 0 | control | flush bits |
| 1 | transmit data | write pushes a byte |
| 2 | receive data | read pops a byte |
| 3 | thresholds | read/write |
| 4 | raw status | read |
| 5 | mask | read/write |
| 6 | masked status | read |
| 7 | clear | write one to clear |

Read data is combinational on `regRdata` during the cycle of the access. A write takes effect at the clock edge that ends the access.

Top module: `serbus_fifo_irq`

## Requirements
- R1: After reset, both FIFOs are empty, the thresholds, mask and latched bits are 0, `irqOut` is low, `engTxValid` is 0, `engRxReady` is 1, and raw status (regSel 4) reads 0x00000033.
- R2: Each byte written to regSel 1 enters the transmit FIFO, which holds up to 16 bytes. The bytes appear on `engTxData` in order. `engTxValid` is 1 while the FIFO is not empty, and each `engTxTake` removes one byte. Raw bit 0 shows the FIFO empty and raw bit 2 shows it full.
- R3: When `engRxReady` is 1, `engRxPut` stores `engRxData` in the receive FIFO. A put while the FIFO is full is dropped. Each read of regSel 2 returns the oldest byte on `regRdata[7:0]` and removes it. A read while the FIFO is empty returns 0 and removes nothing. Raw bit 4 shows the FIFO empty and raw bit 6 shows it full.
- R4: The threshold register (regSel 3) holds the transmit threshold in bits [3:0] and the receive threshold in bits [11:8]. Raw bit 1 is 1 while the transmit occupancy is less than or equal to the transmit threshold. Raw bit 5 is 1 while the receive occupancy is greater than or equal to the receive threshold.
- R5: A write to regSel 1 while the transmit FIFO is full sets raw bit 3, and that bit stays set. The byte is discarded and the FIFO contents are unchanged.
- R6: Writing 1 to control bit 0 flushes the transmit FIFO, and writing 1 to control bit 1 flushes the receive FIFO. Each bit reads back 1 for exactly FLUSH_CYCLES (default 4) cycles after the write edge, then reads 0. From then on, the FIFO is empty.
- R7: While a FIFO is being flushed, pushes and pops on it from both sides are ignored. During the flush, `engTxValid` or `engRxReady` reads 0 and a read of regSel 2 returns 0. A transmit write during a transmit flush does not set raw bit 3.
- R8: A one-cycle pulse sets a latched raw bit: `evDone` sets bit 19, `evArbLost` sets bit 24, `evBusErr` sets bit 25 and `evDoneNoStop` sets bit 28.
- R9: Writing a 1 to a bit of the clear register (regSel 7) clears that latched raw bit. Only bits within 0x131F007F take effect. An event that arrives in the same cycle as its clear still sets the bit. The FIFO state bits keep following the FIFOs.
- R10: Bits 31:29 of the mask register (regSel 5) always read 0. Masked status (regSel 6) equals raw status AND mask. `irqOut` is 1 exactly when the masked status is nonzero. Raw bits that have no source always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 3 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops on regSel 2) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| engTxValid | output | 1 | Transmit byte available to the engine |
| engTxData | output | 8 | Oldest transmit byte |
| engTxTake | input | 1 | Engine removes the oldest transmit byte |
| engRxPut | input | 1 | Engine stores a received byte |
| engRxData | input | 8 | Received byte |
| engRxReady | output | 1 | Receive FIFO can accept a byte |
| evDone | input | 1 | Transaction done with stop, pulse |
| evArbLost | input | 1 | Arbitration lost, pulse |
| evBusErr | input | 1 | Bus error, pulse |
| evDoneNoStop | input | 1 | Transaction done without stop, pulse |
| irqOut | output | 1 | Combined interrupt |

## Verification
The assertions assume that FLUSH_CYCLES is at least 1 and that event inputs are one-cycle pulses. They also assume that `regSel` is always a defined value, because the read mux is compared against it every cycle. The stimulus holds every strobe at 0 except in the single cycle of a task call. It raises `engTxTake` and `engRxPut` even when the handshake refuses them, so that the guarding inside the block is exercised rather than avoided.

// File: rtl/serbus_fifo_pkg.sv
package serbus_fifo_pkg;
  localparam int BYTE_W = 8;
  localparam int THR_W  = 4;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_TXD   = 3'd1;
  localparam logic [2:0] SEL_RXD   = 3'd2;
  localparam logic [2:0] SEL_THR   = 3'd3;
  localparam logic [2:0] SEL_RAW   = 3'd4;
  localparam logic [2:0] SEL_MASK  = 3'd5;
  localparam logic [2:0] SEL_MSTAT = 3'd6;
  localparam logic [2:0] SEL_CLR   = 3'd7;

  // interrupt source positions, decoded by software
  localparam int IB_TX_EMPTY  = 0;
  localparam int IB_TX_NEAR   = 1;
  localparam int IB_TX_FULL   = 2;
  localparam int IB_TX_OVR    = 3;
  localparam int IB_RX_EMPTY  = 4;
  localparam int IB_RX_NEAR   = 5;
  localparam int IB_RX_FULL   = 6;
  localparam int IB_DONE      = 19;
  localparam int IB_ARB       = 24;
  localparam int IB_BERR      = 25;
  localparam int IB_DONE_NS   = 28;

  localparam logic [31:0] CLR_SET = 32'h131F_007F;
  localparam logic [31:0] MASK_WR = 32'h1FFF_FFFF;

  typedef struct packed {
    logic              txPush;
    logic [BYTE_W-1:0] txByte;
    logic              rxPop;
    logic              txClr;
    logic              rxClr;
    logic              txBlock;
    logic              rxBlock;
  } fifo_strobe_t;
endpackage

// File: rtl/serbus_byte_fifo.sv
module serbus_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  input  logic          clr,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= stepPtr(wrPtr);
      if (doPop)  rdPtr <= stepPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/serbus_fifo_dp.sv
module serbus_fifo_dp
  import serbus_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifo_strobe_t      strobe,
  input  logic              engTxTake,
  input  logic              engRxPut,
  input  logic [BYTE_W-1:0] engRxData,
  output logic              engTxValid,
  output logic [BYTE_W-1:0] engTxData,
  output logic              engRxReady,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount,
  output logic [BYTE_W-1:0] rxHead
);
  serbus_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) txFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pushData(strobe.txByte),
    .pop(engTxTake && !strobe.txBlock), .clr(strobe.txClr),
    .headData(engTxData), .count(txCount)
  );

  serbus_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) rxFifo_i (
    .clk(clk), .rstN(rstN),
    .push(engRxPut && !strobe.rxBlock), .pushData(engRxData),
    .pop(strobe.rxPop), .clr(strobe.rxClr),
    .headData(rxHead), .count(rxCount)
  );

  assign engTxValid = (txCount != '0) && !strobe.txBlock;
  assign engRxReady = (rxCount != CW'(DEPTH)) && !strobe.rxBlock;
endmodule

// File: rtl/serbus_fifo_ctl.sv
module serbus_fifo_ctl
  import serbus_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FLUSH_CYCLES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FCW = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              evDone,
  input  logic              evArbLost,
  input  logic              evBusErr,
  input  logic              evDoneNoStop,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic [BYTE_W-1:0] rxHead,
  output fifo_strobe_t      strobe,
  output logic [31:0]       rawVec,
  output logic [31:0]       maskReg,
  output logic              txBusy,
  output logic              rxBusy,
  output logic              irqOut
);
  logic [1:0][FCW-1:0] flushCnt;
  logic [1:0]          flushBusy, flushEnd;
  logic [THR_W-1:0]    txThr, rxThr;
  logic [31:0]         stickyBits, setVec, clrVec, levelVec, mstat;
  logic                txWr, txFull, ovrSet;

  // one self-clearing flush counter per direction (0 = tx, 1 = rx)
  for (genvar f = 0; f < 2; f++) begin : g_flush
    logic startF;
    assign flushBusy[f] = flushCnt[f] != '0;
    assign flushEnd[f]  = flushCnt[f] == FCW'(1);
    assign startF = regWr && (regSel == SEL_CTRL) && regWdata[f] && !flushBusy[f];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              flushCnt[f] <= '0;
      else if (startF)        flushCnt[f] <= FCW'(FLUSH_CYCLES);
      else if (flushBusy[f])  flushCnt[f] <= flushCnt[f] - 1'b1;
    end
  end

  assign txBusy = flushBusy[0];
  assign rxBusy = flushBusy[1];

  assign txWr   = regWr && (regSel == SEL_TXD);
  assign txFull = txCount == CW'(DEPTH);
  assign ovrSet = txWr && !txBusy && txFull;

  always_comb begin
    strobe.txPush  = txWr && !txBusy && !txFull;
    strobe.txByte  = regWdata[BYTE_W-1:0];
    strobe.rxPop   = regRd && (regSel == SEL_RXD) && (rxCount != '0) && !rxBusy;
    strobe.txClr   = flushEnd[0];
    strobe.rxClr   = flushEnd[1];
    strobe.txBlock = txBusy;
    strobe.rxBlock = rxBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThr   <= '0;
      rxThr   <= '0;
      maskReg <= '0;
    end else if (regWr) begin
      if (regSel == SEL_THR) begin
        txThr <= regWdata[THR_W-1:0];
        rxThr <= regWdata[8 +: THR_W];
      end
      if (regSel == SEL_MASK) maskReg <= regWdata & MASK_WR;
    end
  end

  always_comb begin
    setVec = '0;
    setVec[IB_TX_OVR]  = ovrSet;
    setVec[IB_DONE]    = evDone;
    setVec[IB_ARB]     = evArbLost;
    setVec[IB_BERR]    = evBusErr;
    setVec[IB_DONE_NS] = evDoneNoStop;
    clrVec = (regWr && (regSel == SEL_CLR)) ? (regWdata & CLR_SET) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyBits <= '0;
    else       stickyBits <= (stickyBits & ~clrVec) | setVec;
  end

  always_comb begin
    levelVec = '0;
    levelVec[IB_TX_EMPTY] = txCount == '0;
    levelVec[IB_TX_NEAR]  = txCount <= CW'(txThr);
    levelVec[IB_TX_FULL]  = txFull;
    levelVec[IB_RX_EMPTY] = rxCount == '0;
    levelVec[IB_RX_NEAR]  = rxCount >= CW'(rxThr);
    levelVec[IB_RX_FULL]  = rxCount == CW'(DEPTH);
  end

  assign rawVec = levelVec | stickyBits;
  assign mstat  = rawVec & maskReg;
  assign irqOut = |mstat;

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_CTRL:  regRdata = {30'b0, rxBusy, txBusy};
      SEL_RXD:   if ((rxCount != '0) && !rxBusy) regRdata = 32'(rxHead);
      SEL_THR:   regRdata = {20'b0, rxThr, 4'b0, txThr};
      SEL_RAW:   regRdata = rawVec;
      SEL_MASK:  regRdata = maskReg;
      SEL_MSTAT: regRdata = mstat;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/serbus_fifo_irq.sv
module serbus_fifo_irq
  import serbus_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regSel,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        engTxValid,
  output logic [7:0]  engTxData,
  input  logic        engTxTake,
  input  logic        engRxPut,
  input  logic [7:0]  engRxData,
  output logic        engRxReady,
  input  logic        evDone,
  input  logic        evArbLost,
  input  logic        evBusErr,
  input  logic        evDoneNoStop,
  output logic        irqOut
);
  localparam int CW = $clog2(DEPTH + 1);

  fifo_strobe_t      strobe;
  logic [CW-1:0]     txCount, rxCount;
  logic [BYTE_W-1:0] rxHead;
  logic [31:0]       rawVec, maskReg;
  logic              txBusy, rxBusy;

  serbus_fifo_ctl #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) ctl_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .evDone(evDone), .evArbLost(evArbLost), .evBusErr(evBusErr),
    .evDoneNoStop(evDoneNoStop),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .strobe(strobe), .rawVec(rawVec), .maskReg(maskReg),
    .txBusy(txBusy), .rxBusy(rxBusy), .irqOut(irqOut)
  );

  serbus_fifo_dp #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .engTxTake(engTxTake), .engRxPut(engRxPut), .engRxData(engRxData),
    .engTxValid(engTxValid), .engTxData(engTxData), .engRxReady(engRxReady),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead)
  );
endmodule

// File: rtl/serbus_fifo_irq_chk.sv
module serbus_fifo_irq_chk
  import serbus_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [2:0]    regSel,
  input logic          regWr,
  input logic [31:0]   regRdata,
  input logic          evArbLost,
  input logic          evDone,
  input logic          irqOut,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input logic [31:0]   rawVec,
  input logic [31:0]   maskReg,
  input logic          txBusy,
  input logic          rxBusy
);
  // R2
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && (regSel == SEL_TXD) && (txCount == CW'(DEPTH)) && !txBusy) |=> rawVec[IB_TX_OVR]);

  // R7
  flush_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy || rxBusy) |=> ((!$past(txBusy) || txCount == $past(txCount) || txCount == '0) &&
                            (!$past(rxBusy) || rxCount == $past(rxCount) || rxCount == '0)));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> (txCount == '0));

  // R8
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evArbLost || evDone) |=> (rawVec[IB_ARB] || !$past(evArbLost)) && (rawVec[IB_DONE] || !$past(evDone)));

  // R10
  mask_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_MASK) |-> (regRdata[31:29] == 3'b000));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irqOut);
endmodule

bind serbus_fifo_irq serbus_fifo_irq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRdata(regRdata),
  .evArbLost(evArbLost), .evDone(evDone), .irqOut(irqOut),
  .txCount(txCount), .rxCount(rxCount), .rawVec(rawVec), .maskReg(maskReg),
  .txBusy(txBusy), .rxBusy(rxBusy)
);

// File: tb/serbus_fifo_irq_tb.sv
`timescale 1ns/1ps
module serbus_fifo_irq_tb_top;
  localparam int DEPTH = 16;
  localparam int FLUSH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        engTxValid, engRxReady, irqOut;
  logic [7:0]  engTxData;
  logic        engTxTake = 1'b0, engRxPut = 1'b0;
  logic [7:0]  engRxData = '0;
  logic        evDone = 1'b0, evArbLost = 1'b0, evBusErr = 1'b0, evDoneNoStop = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serbus_fifo_irq #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); regSel = s; regWdata = d; regWr = 1'b1;
    @(posedge clk); #1 regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); regSel = s; regRd = 1'b1;
    #1 d = regRdata;
    @(posedge clk); #1 regRd = 1'b0;
  endtask

  task automatic engPut(input logic [7:0] b);
    @(negedge clk); engRxData = b; engRxPut = 1'b1;
    @(posedge clk); #1 engRxPut = 1'b0;
  endtask

  task automatic engTake(output logic v, output logic [7:0] b);
    @(negedge clk); #1 v = engTxValid; b = engTxData; engTxTake = 1'b1;
    @(posedge clk); #1 engTxTake = 1'b0;
  endtask

  task automatic waitFlush(input int bitIdx);
    logic [31:0] d;
    for (int k = 0; k < 20; k++) begin
      regRead(3'd0, d);
      if (!d[bitIdx]) break;
    end
  endtask

  function automatic logic [7:0] txPat(input int i);
    return 8'(i * 37 + 5);
  endfunction
  function automatic logic [7:0] rxPat(input int i);
    return 8'(i * 91 + 13);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    logic [7:0] b;
    int n;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    #1 chk("R1 engTxValid", 32'(engTxValid), 32'd0);
    chk("R1 engRxReady", 32'(engRxReady), 32'd1);
    chk("R1 irqOut", 32'(irqOut), 32'd0);
    regRead(3'd4, d); chk("R1 raw", d, 32'h33);
    regRead(3'd0, d); chk("R1 ctrl", d, 32'h0);
    regRead(3'd3, d); chk("R1 thr", d, 32'h0);
    regRead(3'd5, d); chk("R1 mask", d, 32'h0);

    // R2 R4 transmit level sweep over every occupancy and threshold
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int t = 0; t < 16; t++) begin
        regWrite(3'd3, 32'(t));
        regRead(3'd4, d);
        chk("R2/R4 tx raw bits", d & 32'h7,
            32'(lvl == 0) | (32'(lvl <= t) << 1) | (32'(lvl == DEPTH) << 2));
      end
      if (lvl < DEPTH) regWrite(3'd1, 32'(txPat(lvl)));
    end
    // R5 overrun on full
    regWrite(3'd1, 32'hEE);
    regRead(3'd4, d); chk("R5 overrun bit", d & 32'h8, 32'h8);
    for (int i = 0; i < DEPTH; i++) begin
      engTake(v, b);
      chk("R2 tx valid", 32'(v), 32'd1);
      chk("R2 tx order", 32'(b), 32'(txPat(i)));
    end
    #1 chk("R5 no extra byte", 32'(engTxValid), 32'd0);
    regRead(3'd4, d); chk("R5 overrun sticky", d & 32'h9, 32'h9);
    regWrite(3'd7, 32'h8);
    regRead(3'd4, d); chk("R9 overrun cleared", d & 32'h8, 32'h0);

    // R3 R4 receive level sweep
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int t = 0; t < 16; t++) begin
        regWrite(3'd3, 32'(t) << 8);
        regRead(3'd4, d);
        chk("R3/R4 rx raw bits", d & 32'h70,
            (32'(lvl == 0) << 4) | (32'(lvl >= t) << 5) | (32'(lvl == DEPTH) << 6));
      end
      #1 chk("R3 rx ready", 32'(engRxReady), 32'(lvl < DEPTH));
      engPut(rxPat(lvl));
    end
    for (int i = 0; i < DEPTH; i++) begin
      regRead(3'd2, d); chk("R3 rx order", d, 32'(rxPat(i)));
    end
    regRead(3'd2, d); chk("R3 empty read", d, 32'h0);
    regRead(3'd4, d); chk("R3 rx empty bit", d & 32'h10, 32'h10);

    // R6 transmit flush duration
    for (int i = 0; i < 5; i++) regWrite(3'd1, 32'(i));
    regWrite(3'd0, 32'h1);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      regRead(3'd0, d);
      if (d[0]) n++; else break;
    end
    chk("R6 tx flush cycles", 32'(n), 32'(FLUSH));
    regRead(3'd4, d); chk("R6 tx empty after flush", d & 32'h1, 32'h1);
    #1 chk("R6 tx valid after flush", 32'(engTxValid), 32'd0);

    // R7 activity during a transmit flush is ignored
    for (int i = 0; i < 3; i++) regWrite(3'd1, 32'(i + 1));
    regWrite(3'd0, 32'h1);
    regWrite(3'd1, 32'h77);
    engTake(v, b); chk("R7 tx valid during flush", 32'(v), 32'd0);
    waitFlush(0);
    #1 chk("R7 tx empty after flush", 32'(engTxValid), 32'd0);
    regWrite(3'd1, 32'hA5);
    engTake(v, b); chk("R7 tx first byte after flush", 32'(b), 32'hA5);

    // R7 full transmit FIFO write during flush raises no overrun
    for (int i = 0; i < DEPTH; i++) regWrite(3'd1, 32'(i));
    regWrite(3'd0, 32'h1);
    regWrite(3'd1, 32'h55);
    waitFlush(0);
    regRead(3'd4, d); chk("R7 no overrun during flush", d & 32'h8, 32'h0);

    // R6 R7 receive flush
    for (int i = 0; i < 4; i++) engPut(rxPat(i));
    regWrite(3'd0, 32'h2);
    #1 chk("R7 rx ready during flush", 32'(engRxReady), 32'd0);
    engPut(8'h99);
    regRead(3'd2, d); chk("R7 rx read during flush", d, 32'h0);
    waitFlush(1);
    regRead(3'd2, d); chk("R6 rx empty after flush", d, 32'h0);
    regRead(3'd4, d); chk("R6 rx empty bit", d & 32'h10, 32'h10);

    // R8 engine events
    regWrite(3'd3, 32'h0);
    @(negedge clk) evDone = 1'b1; @(posedge clk); #1 evDone = 1'b0;
    regRead(3'd4, d); chk("R8 done bit19", d & 32'h0008_0000, 32'h0008_0000);
    @(negedge clk) evArbLost = 1'b1; @(posedge clk); #1 evArbLost = 1'b0;
    regRead(3'd4, d); chk("R8 arb bit24", d & 32'h0100_0000, 32'h0100_0000);
    @(negedge clk) evBusErr = 1'b1; @(posedge clk); #1 evBusErr = 1'b0;
    regRead(3'd4, d); chk("R8 berr bit25", d & 32'h0200_0000, 32'h0200_0000);
    @(negedge clk) evDoneNoStop = 1'b1; @(posedge clk); #1 evDoneNoStop = 1'b0;
    regRead(3'd4, d); chk("R8 all events", d, 32'h1308_0033);

    // R9 clear everything; level bits stay
    regWrite(3'd7, 32'hFFFF_FFFF);
    regRead(3'd4, d); chk("R9 clear all", d, 32'h33);
    // R9 set wins over clear in the same cycle
    @(negedge clk) regSel = 3'd7; regWdata = 32'h0200_0000; regWr = 1'b1; evBusErr = 1'b1;
    @(posedge clk); #1 regWr = 1'b0; evBusErr = 1'b0;
    regRead(3'd4, d); chk("R9 set wins", d & 32'h0200_0000, 32'h0200_0000);
    regWrite(3'd7, 32'h0200_0000);
    regRead(3'd4, d); chk("R9 berr cleared", d, 32'h33);

    // R10 mask and masked status
    regWrite(3'd5, 32'hFFFF_FFFF);
    regRead(3'd5, d); chk("R10 mask reserved", d, 32'h1FFF_FFFF);
    @(negedge clk) evDone = 1'b1; evDoneNoStop = 1'b1;
    @(posedge clk); #1 evDone = 1'b0; evDoneNoStop = 1'b0;
    regRead(3'd4, d); chk("R10 raw only sources", d, 32'h1008_0033);
    for (int bi = 0; bi < 32; bi++) begin
      regWrite(3'd5, 32'h1 << bi);
      regRead(3'd6, d);
      chk("R10 masked status", d, 32'h1008_0033 & (32'h1 << bi) & 32'h1FFF_FFFF);
      chk("R10 irq", 32'(irqOut), 32'(((32'h1008_0033 & (32'h1 << bi) & 32'h1FFF_FFFF) != 0)));
    end
    regWrite(3'd5, 32'h0);
    #1 chk("R10 irq masked off", 32'(irqOut), 32'd0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule